// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt Shaping

This block is an 8-bit binary down-counter for a low-power timekeeping chip. Its count is advanced by one of four tick-enable inputs. The ticks come from a 32.768 kHz prescaler chain outside the block and run at 4096 Hz, 64 Hz, 1 Hz and one tick per minute. Software writes a start value and picks the tick source. It then enables counting. At each period end the block raises a sticky expiry flag and reloads the start value. Software reads the live count back at any time.

The interrupt output has two modes. In level mode it follows the expiry flag. In pulsed mode it shows one pulse per period. Both modes are gated by an interrupt-enable bit.

Two state machines do the work. The run FSM has three states. ST_STOP means counting is disabled. ST_COUNT means the count is enabled and nonzero. ST_EMPTY means the count is enabled and zero. Its transitions are STOP→COUNT (enable set with a nonzero count), STOP→EMPTY (enable set with a zero count), COUNT→EMPTY (zero loaded), EMPTY→COUNT (nonzero loaded), and COUNT/EMPTY→STOP (enable cleared). The pulse FSM has two states, P_IDLE and P_HOLD. It goes IDLE→HOLD on a period end. It goes HOLD→IDLE on the release tick. A new period end during HOLD keeps it in HOLD.

Top module: `countdown_timer`

## Requirements
- R1: After reset, the control register (address 0xE) reads 0x03, which means disabled with the per-minute source selected. The count register (0xF) reads 0x00, the interrupt register (0x1) reads 0x00, and `irq` is low.
- R2: A write to the count register loads both the live count and the reload value. Reading the count register returns the live count.
- R3: The control register layout is: bit 7 enables counting, and bits 1:0 select the source (0 = 4096 Hz, 1 = 64 Hz, 2 = 1 Hz, 3 = per minute). The count changes only on a tick of the selected source while the block is enabled. When disabled, the count holds.
- R4: A selected tick that arrives while the count is 1 sets the expiry flag. On the same edge the count is reloaded from the reload value. Any other selected tick on a nonzero count decrements it by one.
- R5: The interrupt register layout is: bit 0 is interrupt enable, bit 1 selects pulsed mode, and bit 2 is the expiry flag. The flag is sticky. Only a write to 0x1 with bit 2 at 0 clears it, and a write with bit 2 at 1 leaves it unchanged. A period end in the same cycle as a clearing write wins.
- R6: In level mode, `irq` equals the expiry flag while interrupt enable is set.
- R7: In pulsed mode, `irq` rises on the edge of a period end. If the source is 4096 Hz or 64 Hz, it falls on the next selected tick that does not end a period. If the source is 1 Hz or per minute, it falls on the next 64 Hz tick that does not end a period.
- R8: With interrupt enable clear, `irq` stays low whatever the flag or the pulse state.
- R9: With a count of zero, ticks neither change the count nor set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| tick_4096 | input | 1 | One-cycle 4096 Hz tick enable |
| tick_64 | input | 1 | One-cycle 64 Hz tick enable |
| tick_1 | input | 1 | One-cycle 1 Hz tick enable |
| tick_min | input | 1 | One-cycle per-minute tick enable |
| irq | output | 1 | Timer interrupt, active high |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 4-bit address, and the control, count and interrupt registers at 0xE, 0xF and 0x1. The tick enables are plain inputs, so the bench raises each rate's tick directly. This means the per-minute and 1 Hz sources, and the slow-source pulse release on a 64 Hz tick, take a handful of cycles to exercise instead of real seconds. Short reload values such as 1 and 2 make a period end, the pulse hold across a non-releasing tick, and the clash between a clearing write and a period end in the same cycle all reachable in a few steps.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_COUNT = 2'd1,
        ST_EMPTY = 2'd2
    } run_state_e;

    typedef enum logic {
        P_IDLE = 1'b0,
        P_HOLD = 1'b1
    } pulse_state_e;

    typedef enum logic [1:0] {
        SRC_4096 = 2'd0,
        SRC_64   = 2'd1,
        SRC_1    = 2'd2,
        SRC_MIN  = 2'd3
    } src_sel_e;
endpackage

// File: rtl/cdt_tick_mux.sv
module cdt_tick_mux
    import cdt_pkg::*;
#(
    parameter int NSRC = 4,
    localparam int SELW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] ticks,
    input  logic [SELW-1:0] sel,
    output logic            tick_sel,
    output logic            tick_rel
);
    // The pulse of a slow source is released by the 64 Hz tick.
    always_comb begin
        tick_sel = ticks[sel];
        if (sel == SELW'(SRC_1) || sel == SELW'(SRC_MIN))
            tick_rel = ticks[SRC_64];
        else
            tick_rel = tick_sel;
    end
endmodule

// File: rtl/cdt_count_core.sv
module cdt_count_core
    import cdt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_q,
    input  logic          en_nxt,
    input  logic          tick_sel,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] cnt_q,
    output logic [DW-1:0] reload_q,
    output logic          expire
);
    run_state_e    state_q, state_d;
    logic [DW-1:0] cnt_d;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        unique case (state_q)
            ST_STOP:  cnt_d = cnt_q;
            ST_EMPTY: cnt_d = cnt_q;
            ST_COUNT: begin
                if (tick_sel && en_q) begin
                    if (cnt_q == DW'(1)) begin
                        expire = 1'b1;
                        cnt_d  = reload_q;
                    end else begin
                        cnt_d = cnt_q - DW'(1);
                    end
                end
            end
            default:  cnt_d = cnt_q;
        endcase
        if (load)
            cnt_d = load_val;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (en_nxt)
                    state_d = (cnt_d == '0) ? ST_EMPTY : ST_COUNT;
            end
            ST_COUNT: begin
                if (!en_nxt)           state_d = ST_STOP;
                else if (cnt_d == '0)  state_d = ST_EMPTY;
            end
            ST_EMPTY: begin
                if (!en_nxt)           state_d = ST_STOP;
                else if (cnt_d != '0)  state_d = ST_COUNT;
            end
            default: state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_STOP;
            cnt_q    <= '0;
            reload_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (load)
                reload_q <= load_val;
        end
    end
endmodule

// File: rtl/cdt_irq_shaper.sv
module cdt_irq_shaper
    import cdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic tick_rel,
    input  logic flag_q,
    input  logic ie_q,
    input  logic pulse_mode_q,
    output logic irq
);
    pulse_state_e pst_q, pst_d;

    always_comb begin
        pst_d = pst_q;
        unique case (pst_q)
            P_IDLE: if (expire) pst_d = P_HOLD;
            P_HOLD: begin
                if (expire)        pst_d = P_HOLD;
                else if (tick_rel) pst_d = P_IDLE;
            end
            default: pst_d = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pst_q <= P_IDLE;
        else        pst_q <= pst_d;
    end

    always_comb begin
        if (!ie_q)             irq = 1'b0;
        else if (pulse_mode_q) irq = (pst_q == P_HOLD);
        else                   irq = flag_q;
    end
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
    import cdt_pkg::*;
#(
    parameter int          AW        = 4,
    parameter int          DW        = 8,
    parameter logic [AW-1:0] CTRL_ADDR = 4'hE,
    parameter logic [AW-1:0] CNT_ADDR  = 4'hF,
    parameter logic [AW-1:0] IRQ_ADDR  = 4'h1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          tick_4096,
    input  logic          tick_64,
    input  logic          tick_1,
    input  logic          tick_min,
    output logic          irq
);
    localparam int NSRC     = 4;
    localparam int SELW     = $clog2(NSRC);
    localparam int EN_BIT   = DW - 1;
    localparam int IE_BIT   = 0;
    localparam int MODE_BIT = 1;
    localparam int FLAG_BIT = 2;

    logic            en_q, en_nxt, ie_q, pulse_mode_q, flag_q;
    logic [SELW-1:0] sel_q;
    logic [DW-1:0]   cnt_q, reload_q;
    logic            tick_sel, tick_rel, expire;
    logic            ctrl_wr, cnt_wr, irq_wr;

    assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);
    assign cnt_wr  = wr_en && (wr_addr == CNT_ADDR);
    assign irq_wr  = wr_en && (wr_addr == IRQ_ADDR);
    assign en_nxt  = ctrl_wr ? wr_data[EN_BIT] : en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q         <= 1'b0;
            sel_q        <= SELW'(SRC_MIN);
            ie_q         <= 1'b0;
            pulse_mode_q <= 1'b0;
            flag_q       <= 1'b0;
        end else begin
            en_q <= en_nxt;
            if (ctrl_wr)
                sel_q <= wr_data[SELW-1:0];
            if (irq_wr) begin
                ie_q         <= wr_data[IE_BIT];
                pulse_mode_q <= wr_data[MODE_BIT];
            end
            if (expire)
                flag_q <= 1'b1;
            else if (irq_wr && !wr_data[FLAG_BIT])
                flag_q <= 1'b0;
        end
    end

    cdt_tick_mux #(.NSRC(NSRC)) u_mux (
        .ticks    ({tick_min, tick_1, tick_64, tick_4096}),
        .sel      (sel_q),
        .tick_sel (tick_sel),
        .tick_rel (tick_rel)
    );

    cdt_count_core #(.DW(DW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_q     (en_q),
        .en_nxt   (en_nxt),
        .tick_sel (tick_sel),
        .load     (cnt_wr),
        .load_val (wr_data),
        .cnt_q    (cnt_q),
        .reload_q (reload_q),
        .expire   (expire)
    );

    cdt_irq_shaper u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .expire       (expire),
        .tick_rel     (tick_rel),
        .flag_q       (flag_q),
        .ie_q         (ie_q),
        .pulse_mode_q (pulse_mode_q),
        .irq          (irq)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_ADDR)
            rd_data = {en_q, {(DW-1-SELW){1'b0}}, sel_q};
        else if (rd_addr == CNT_ADDR)
            rd_data = cnt_q;
        else if (rd_addr == IRQ_ADDR)
            rd_data = {{(DW-3){1'b0}}, flag_q, pulse_mode_q, ie_q};
    end
endmodule

// File: rtl/countdown_timer_chk.sv
module countdown_timer_chk #(
    parameter int            AW       = 4,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] CNT_ADDR = 4'hF,
    parameter logic [AW-1:0] IRQ_ADDR = 4'h1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          irq,
    input logic          en_q,
    input logic          ie_q,
    input logic          flag_q,
    input logic          tick_sel,
    input logic [DW-1:0] cnt_q,
    input logic [DW-1:0] reload_q
);
    logic cnt_load, flag_clear;
    assign cnt_load   = wr_en && (wr_addr == CNT_ADDR);
    assign flag_clear = wr_en && (wr_addr == IRQ_ADDR) && !wr_data[2];

    // R3
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !cnt_load) |=> $stable(cnt_q));

    // R4
    expiry_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && tick_sel && cnt_q == DW'(1) && !cnt_load)
            |=> (flag_q && cnt_q == $past(reload_q)));

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clear) |=> flag_q);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q |-> !irq);

    // R9
    zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !cnt_load) |=> (cnt_q == '0));
endmodule

bind countdown_timer countdown_timer_chk #(
    .AW(AW), .DW(DW), .CNT_ADDR(CNT_ADDR), .IRQ_ADDR(IRQ_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .irq      (irq),
    .en_q     (en_q),
    .ie_q     (ie_q),
    .flag_q   (flag_q),
    .tick_sel (tick_sel),
    .cnt_q    (cnt_q),
    .reload_q (reload_q)
);

// File: tb/countdown_timer_test.sv
module countdown_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tick_4096 = 1'b0, tick_64 = 1'b0, tick_1 = 1'b0, tick_min = 1'b0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    countdown_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick_4096(tick_4096), .tick_64(tick_64), .tick_1(tick_1),
        .tick_min(tick_min), .irq(irq)
    );

    // op: 0 write, 1 tick (data bit0 4096, bit1 64, bit2 1 Hz, bit3 minute),
    //     2 read check, 3 irq check (exp bit 0). Fields {op, addr, data, exp, req}.
    localparam int NV = 47;
    localparam logic [25:0] VEC [NV] = '{
        {2'd2, 4'hE, 8'h00, 8'h03, 4'd1},   // R1
        {2'd2, 4'hF, 8'h00, 8'h00, 4'd1},   // R1
        {2'd2, 4'h1, 8'h00, 8'h00, 4'd1},   // R1
        {2'd3, 4'h0, 8'h00, 8'h00, 4'd1},   // R1
        {2'd0, 4'hF, 8'h03, 8'h00, 4'd2},
        {2'd2, 4'hF, 8'h00, 8'h03, 4'd2},   // R2
        {2'd1, 4'h0, 8'h08, 8'h00, 4'd3},
        {2'd2, 4'hF, 8'h00, 8'h03, 4'd3},   // R3 disabled holds
        {2'd0, 4'hE, 8'h80, 8'h00, 4'd3},
        {2'd1, 4'h0, 8'h02, 8'h00, 4'd3},
        {2'd2, 4'hF, 8'h00, 8'h03, 4'd3},   // R3 unselected tick
        {2'd1, 4'h0, 8'h01, 8'h00, 4'd3},
        {2'd2, 4'hF, 8'h00, 8'h02, 4'd3},   // R3 decrement
        {2'd1, 4'h0, 8'h01, 8'h00, 4'd4},
        {2'd2, 4'hF, 8'h00, 8'h01, 4'd4},   // R4
        {2'd0, 4'h1, 8'h01, 8'h00, 4'd6},
        {2'd1, 4'h0, 8'h01, 8'h00, 4'd4},
        {2'd2, 4'hF, 8'h00, 8'h03, 4'd4},   // R4 reload
        {2'd2, 4'h1, 8'h00, 8'h05, 4'd4},   // R4 flag
        {2'd3, 4'h0, 8'h00, 8'h01, 4'd6},   // R6
        {2'd0, 4'h1, 8'h05, 8'h00, 4'd5},
        {2'd2, 4'h1, 8'h00, 8'h05, 4'd5},   // R5 write 1 keeps flag
        {2'd0, 4'h1, 8'h01, 8'h00, 4'd5},
        {2'd2, 4'h1, 8'h00, 8'h01, 4'd5},   // R5 clear
        {2'd3, 4'h0, 8'h00, 8'h00, 4'd6},   // R6
        {2'd0, 4'h1, 8'h03, 8'h00, 4'd7},
        {2'd0, 4'hF, 8'h02, 8'h00, 4'd7},
        {2'd1, 4'h0, 8'h01, 8'h00, 4'd7},
        {2'd3, 4'h0, 8'h00, 8'h00, 4'd7},   // R7 no pulse yet
        {2'd1, 4'h0, 8'h01, 8'h00, 4'd7},
        {2'd3, 4'h0, 8'h00, 8'h01, 4'd7},   // R7 pulse up
        {2'd1, 4'h0, 8'h02, 8'h00, 4'd7},
        {2'd3, 4'h0, 8'h00, 8'h01, 4'd7},   // R7 64 Hz does not release fast source
        {2'd1, 4'h0, 8'h01, 8'h00, 4'd7},
        {2'd3, 4'h0, 8'h00, 8'h00, 4'd7},   // R7 released
        {2'd2, 4'h1, 8'h00, 8'h07, 4'd5},   // R5 flag stays
        {2'd0, 4'hE, 8'h82, 8'h00, 4'd7},
        {2'd0, 4'hF, 8'h01, 8'h00, 4'd7},
        {2'd1, 4'h0, 8'h04, 8'h00, 4'd7},
        {2'd3, 4'h0, 8'h00, 8'h01, 4'd7},   // R7 slow pulse
        {2'd1, 4'h0, 8'h04, 8'h00, 4'd7},
        {2'd3, 4'h0, 8'h00, 8'h01, 4'd7},   // R7 restarted
        {2'd1, 4'h0, 8'h02, 8'h00, 4'd7},
        {2'd3, 4'h0, 8'h00, 8'h00, 4'd7},   // R7 released by 64 Hz
        {2'd0, 4'h1, 8'h04, 8'h00, 4'd8},
        {2'd2, 4'h1, 8'h00, 8'h04, 4'd8},   // R8 flag still set
        {2'd3, 4'h0, 8'h00, 8'h00, 4'd8}    // R8 irq gated
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input logic [3:0] m);
        @(negedge clk);
        {tick_min, tick_1, tick_64, tick_4096} = m;
        @(negedge clk);
        {tick_min, tick_1, tick_64, tick_4096} = 4'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [3:0] a;
            logic [7:0] d, e;
            string      req;
            {op, a, d, e} = VEC[i][25:4];
            req = $sformatf("R%0d", VEC[i][3:0]);
            case (op)
                2'd0: wr(a, d);
                2'd1: tick(d[3:0]);
                2'd2: rd_chk(req, a, e);
                default: check(req, {7'b0, irq}, e);
            endcase
        end

        // R9: zero count ignores ticks
        wr(4'hF, 8'h00);
        tick(4'h4);
        rd_chk("R9", 4'hF, 8'h00);
        wr(4'h1, 8'h01);
        tick(4'h4);
        rd_chk("R9", 4'h1, 8'h01);

        // R5: period end in the same cycle as a clearing write sets the flag
        wr(4'hF, 8'h01);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'h1; wr_data = 8'h01; tick_1 = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1 = 1'b0;
        rd_chk("R5", 4'h1, 8'h05);
        check("R6", {7'b0, irq}, 8'h01);

        // R3: per-minute source
        wr(4'h1, 8'h01);
        wr(4'hE, 8'h83);
        wr(4'hF, 8'h01);
        tick(4'h4);
        rd_chk("R3", 4'h1, 8'h01);
        tick(4'h8);
        rd_chk("R3", 4'hF, 8'h01);
        rd_chk("R3", 4'h1, 8'h05);

        // R1: reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rd_chk("R1", 4'hE, 8'h03);
        rd_chk("R1", 4'hF, 8'h00);
        rd_chk("R1", 4'h1, 8'h00);
        check("R1", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule